// File: doc/BRIEF.md
# Multi-mode asynchronous serial port

This block is a full-duplex asynchronous serial port with one transmit line and one receive line. A two-bit mode input picks the frame format and the bit-rate source. The plain format carries eight data bits between a start bit and a stop bit. The two extended formats add a ninth bit after the data. Software owns that ninth bit and may use it as parity or as an address marker. One extended format runs from the external bit-rate tick. The other runs at a fixed fraction of the system clock.

Software starts a transmission by pulsing a load strobe with a byte and a ninth bit. It later sees a transmit-done flag. On the receive side it reads the last good byte and ninth bit, a receive-done flag it clears itself, and a framing-error flag. The external rate generator supplies a one-cycle tick at sixteen times the bit rate. Both directions count that tick, or the internal fixed divider, sixteen times per bit.

Top module: `sport_top`

## Requirements
- R1: Both lines carry the data byte least significant bit first. The transmit line is high while idle. After reset the transmit line is high and `tx_done`, `rx_done` and `frame_err` are 0.
- R2: Mode 2'b01 uses a 10-bit frame: a low start bit, then data bits 0 to 7, then a high stop bit. Each bit lasts 16 pulses of `rate_tick`. Mode 2'b00 behaves exactly like 2'b01.
- R3: Mode 2'b10 uses the 11-bit frame of R4, but the bit time is fixed by the clock: 64 clock cycles when `rate_double` is 0, and 32 when it is 1. In this mode `rate_tick` has no effect.
- R4: Mode 2'b11 uses an 11-bit frame: start bit, data bits 0 to 7, the ninth bit, then the stop bit. Each bit lasts 16 pulses of `rate_tick`.
- R5: In 11-bit modes the ninth transmitted bit is the value of `tx_bit9` at the accepted load.
- R6: The receiver samples the synchronized line on each 16x tick. A low level must still be low 8 ticks after it was first seen before it counts as a start bit. A shorter low pulse produces no frame and no error.
- R7: When the stop bit samples high, the receiver updates `rx_data` and sets `rx_done`. It also updates `rx_bit9` with the received ninth bit, or with 0 in the 10-bit formats. A good frame also clears `frame_err`.
- R8: When the stop bit samples low, the receiver sets `frame_err`. It leaves `rx_done`, `rx_data` and `rx_bit9` unchanged, and it waits for the line to go high before it looks for the next start bit.
- R9: `tx_done` goes to 1 when the stop bit has been sent. An accepted load clears it. A load pulse while a frame is in progress is ignored.
- R10: A pulse on `rx_clear` clears `rx_done` and `frame_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Frame format and rate source select |
| rate_double | input | 1 | Halves the bit time in the fixed-rate mode |
| rate_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| tx_load | input | 1 | Strobe that starts a transmission |
| tx_data | input | 8 | Byte to transmit |
| tx_bit9 | input | 1 | Ninth bit to transmit |
| tx_line | output | 1 | Serial transmit line |
| tx_done | output | 1 | Transmission complete flag |
| rx_line | input | 1 | Serial receive line |
| rx_clear | input | 1 | Clears the receive-done and framing-error flags |
| rx_data | output | 8 | Last good received byte |
| rx_bit9 | output | 1 | Last good received ninth bit |
| rx_done | output | 1 | Good frame received flag |
| frame_err | output | 1 | Low stop bit seen |

## Verification
The transmitter is run in every mode with bytes whose bit patterns are uneven. A wrong bit order, a missing or extra ninth bit, or a wrong bit time would each change the sampled frame. The fixed-rate mode runs while a fast external tick toggles. Both divider settings are used there, which shows that the internal divider is selected and that the doubling control acts. The receiver gets ninth bits of both values and a short low glitch. It also gets a frame with a low stop bit followed by a good frame. These separate a premature start, an error that corrupts the held data, and an error flag that never clears. A second load strobe in the middle of a frame shows whether it can reach the line.

// File: rtl/sport_pkg.sv
// Package: shared mode encoding and decode helpers for the serial port.
// Assumes the mode input is a two-bit field that is stable during a frame.
package sport_pkg;

    typedef enum logic [1:0] {
        MODE_PLAIN_ALT = 2'b00,
        MODE_PLAIN     = 2'b01,
        MODE_NINE_FIX  = 2'b10,
        MODE_NINE_VAR  = 2'b11
    } sport_mode_e;

    // True when the frame carries the ninth bit.
    function automatic logic has_ninth(input logic [1:0] m);
        return (m == MODE_NINE_FIX) || (m == MODE_NINE_VAR);
    endfunction

    // True when the bit rate comes from the internal divider.
    function automatic logic is_fixed(input logic [1:0] m);
        return m == MODE_NINE_FIX;
    endfunction

endpackage

// File: rtl/sport_rate.sv
// Module: selects the 16x sampling tick. In the fixed mode a free-running
// divider gives one tick every FIXED_DIV/OVS clocks, or half that when
// doubling is on. In the other modes the external tick passes through.
// Assumes FIXED_DIV/OVS is even and at least 2.
module sport_rate
    import sport_pkg::*;
#(
    parameter int OVS       = 16,
    parameter int FIXED_DIV = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       rate_double,
    input  logic       ext_tick,
    output logic       tick
);
    localparam int SLOW = FIXED_DIV / OVS;
    localparam int FAST = SLOW / 2;
    localparam int CW   = (SLOW > 1) ? $clog2(SLOW) : 1;

    logic [CW-1:0] div_cnt;
    logic [CW-1:0] div_lim;
    logic          fixed_sel;
    logic          div_tick;

    // Purpose: choose the divider limit and the tick source.
    always_comb begin
        fixed_sel = is_fixed(mode);
        div_lim   = rate_double ? CW'(FAST - 1) : CW'(SLOW - 1);
        div_tick  = fixed_sel && (div_cnt >= div_lim);
        tick      = fixed_sel ? div_tick : ext_tick;
    end

    // Purpose: free-running divider for the fixed-rate mode.
    always_ff @(posedge clk) begin
        if (!rst_n || !fixed_sel || div_tick) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    // R3: at the slow fixed rate two ticks are never adjacent
    p_fixed_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fixed_sel && !rate_double && $past(fixed_sel) && $past(!rate_double) && tick) |=> !tick);

endmodule

// File: rtl/sport_tx.sv
// Module: transmit shifter. It loads start, data, optional ninth bit and
// stop into a shift register, holds each bit for OVS ticks and raises the
// done flag when the stop bit ends. Assumes the mode is stable during a frame.
module sport_tx
    import sport_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              tick,
    input  logic              load,
    input  logic [DATA_W-1:0] data,
    input  logic              bit9,
    output logic              line,
    output logic              done
);
    localparam int FW = DATA_W + 3;
    localparam int BW = $clog2(FW + 1);
    localparam int TW = $clog2(OVS);

    logic [FW-1:0] shreg;
    logic [BW-1:0] left;
    logic [TW-1:0] tcnt;
    logic          busy;

    assign line = shreg[0];

    // Purpose: accept loads when idle and shift one bit every OVS ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '1;
            left  <= '0;
            tcnt  <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else if (!busy) begin
            if (load) begin
                busy  <= 1'b1;
                done  <= 1'b0;
                tcnt  <= '0;
                shreg <= {1'b1, has_ninth(mode) ? bit9 : 1'b1, data, 1'b0};
                left  <= has_ninth(mode) ? BW'(FW) : BW'(FW - 1);
            end
        end else if (tick) begin
            if (tcnt == TW'(OVS - 1)) begin
                tcnt  <= '0;
                shreg <= {1'b1, shreg[FW-1:1]};
                left  <= left - 1'b1;
                if (left == BW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end else begin
                tcnt <= tcnt + 1'b1;
            end
        end
    end

    // R1: the line rests high whenever no frame is in progress
    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> line);

    // R9: the done flag and an active frame never coexist
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

// File: rtl/sport_rx.sv
// Module: receiver. It synchronizes the line, confirms a start bit at
// mid-bit, samples each following bit every OVS ticks and checks the stop
// bit. A low stop raises the error flag and waits for the line to go high.
// Assumes the mode is stable during a frame.
module sport_rx
    import sport_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              tick,
    input  logic              line,
    input  logic              clear,
    output logic [DATA_W-1:0] data,
    output logic              bit9,
    output logic              done,
    output logic              ferr
);
    localparam int TW   = $clog2(OVS);
    localparam int IW   = $clog2(DATA_W + 2);
    localparam int HALF = OVS / 2;

    typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_STOP, S_HOLD} rx_state_e;

    rx_state_e     state;
    logic          sync1, rx_s;
    logic [DATA_W:0] sh;
    logic [TW-1:0] tcnt;
    logic [IW-1:0] idx;
    logic [IW-1:0] last_idx;
    logic          bit_end;

    // Purpose: decode the last data index and the end of a bit period.
    always_comb begin
        last_idx = has_ninth(mode) ? IW'(DATA_W) : IW'(DATA_W - 1);
        bit_end  = tick && (tcnt == TW'(OVS - 1));
    end

    // Purpose: two-stage synchronizer on the incoming line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b1;
            rx_s  <= 1'b1;
        end else begin
            sync1 <= line;
            rx_s  <= sync1;
        end
    end

    // Purpose: frame sequencing, data capture and flag handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            sh    <= '0;
            tcnt  <= '0;
            idx   <= '0;
            data  <= '0;
            bit9  <= 1'b0;
            done  <= 1'b0;
            ferr  <= 1'b0;
        end else begin
            if (clear) begin
                done <= 1'b0;
                ferr <= 1'b0;
            end
            case (state)
                S_IDLE: begin
                    if (tick && !rx_s) begin
                        state <= S_START;
                        tcnt  <= '0;
                    end
                end
                S_START: begin
                    if (tick) begin
                        if (tcnt == TW'(HALF - 1)) begin
                            tcnt  <= '0;
                            idx   <= '0;
                            state <= rx_s ? S_IDLE : S_DATA;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                end
                S_DATA: begin
                    if (bit_end) begin
                        tcnt <= '0;
                        sh   <= {rx_s, sh[DATA_W:1]};
                        idx  <= idx + 1'b1;
                        if (idx == last_idx) begin
                            state <= S_STOP;
                        end
                    end else if (tick) begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                S_STOP: begin
                    if (bit_end) begin
                        tcnt <= '0;
                        if (rx_s) begin
                            state <= S_IDLE;
                            done  <= 1'b1;
                            ferr  <= 1'b0;
                            if (has_ninth(mode)) begin
                                data <= sh[DATA_W-1:0];
                                bit9 <= sh[DATA_W];
                            end else begin
                                data <= sh[DATA_W:1];
                                bit9 <= 1'b0;
                            end
                        end else begin
                            state <= S_HOLD;
                            ferr  <= 1'b1;
                        end
                    end else if (tick) begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                S_HOLD: begin
                    if (rx_s) begin
                        state <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R7: a new receive-done only follows a high stop sample
    p_done_on_high_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(rx_s));

    // R8: a new framing error only follows a low stop sample
    p_err_on_low_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ferr) |-> $past(!rx_s));

    // R8: a framing error leaves the held byte untouched
    p_err_keeps_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ferr) |-> $stable(data));

endmodule

// File: rtl/sport_top.sv
// Module: top of the multi-mode serial port. It joins the rate selector,
// transmitter and receiver. Assumes rate_tick is a single-cycle pulse
// in the clk domain and that mode changes only between frames.
module sport_top
    import sport_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int OVS       = 16,
    parameter int FIXED_DIV = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              rate_double,
    input  logic              rate_tick,
    input  logic              tx_load,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_bit9,
    output logic              tx_line,
    output logic              tx_done,
    input  logic              rx_line,
    input  logic              rx_clear,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_bit9,
    output logic              rx_done,
    output logic              frame_err
);
    logic tick16;

    sport_rate #(.OVS(OVS), .FIXED_DIV(FIXED_DIV)) u_rate (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .rate_double(rate_double),
        .ext_tick   (rate_tick),
        .tick       (tick16)
    );

    sport_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
        .clk  (clk),
        .rst_n(rst_n),
        .mode (mode),
        .tick (tick16),
        .load (tx_load),
        .data (tx_data),
        .bit9 (tx_bit9),
        .line (tx_line),
        .done (tx_done)
    );

    sport_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
        .clk  (clk),
        .rst_n(rst_n),
        .mode (mode),
        .tick (tick16),
        .line (rx_line),
        .clear(rx_clear),
        .data (rx_data),
        .bit9 (rx_bit9),
        .done (rx_done),
        .ferr (frame_err)
    );

endmodule

// File: tb/sport_top_tb_top.sv
// Bench: directed tests of the serial port, one task per scenario.
module sport_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'b01;
    logic       rate_double = 1'b0;
    logic       rate_tick = 1'b0;
    logic       tx_load = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_bit9 = 1'b0;
    logic       tx_line;
    logic       tx_done;
    logic       rx_line = 1'b1;
    logic       rx_clear = 1'b0;
    logic [7:0] rx_data;
    logic       rx_bit9;
    logic       rx_done;
    logic       frame_err;

    int errors = 0;
    int checks = 0;
    int tick_period = 3;
    int tick_cnt = 0;

    sport_top dut_i (
        .clk(clk), .rst_n(rst_n), .mode(mode), .rate_double(rate_double),
        .rate_tick(rate_tick), .tx_load(tx_load), .tx_data(tx_data),
        .tx_bit9(tx_bit9), .tx_line(tx_line), .tx_done(tx_done),
        .rx_line(rx_line), .rx_clear(rx_clear), .rx_data(rx_data),
        .rx_bit9(rx_bit9), .rx_done(rx_done), .frame_err(frame_err)
    );

    always #10 clk = ~clk;

    // External 16x tick, one pulse every tick_period clocks.
    always @(negedge clk) begin
        if (tick_cnt >= tick_period - 1) begin
            tick_cnt = 0;
            rate_tick = 1'b1;
        end else begin
            tick_cnt = tick_cnt + 1;
            rate_tick = 1'b0;
        end
    end

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int bit_clocks(input logic [1:0] m, input logic dbl, input int tp);
        if (m == 2'b10) return dbl ? 32 : 64;
        return 16 * tp;
    endfunction

    function automatic logic [10:0] frame_bits(input logic [7:0] d, input logic b9, input int nb);
        logic [10:0] f;
        f = '1;
        f[0] = 1'b0;
        f[8:1] = d;
        if (nb == 11) f[9] = b9;
        return f;
    endfunction

    // Pulse the load strobe for one clock.
    task automatic pulse_load(input logic [7:0] d, input logic b9);
        @(negedge clk);
        tx_data = d; tx_bit9 = b9; tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
    endtask

    // Sample the transmit line at each bit centre; called just after a load.
    task automatic collect_tx(input int nb, input int bc, output logic [10:0] got,
                              input logic [7:0] d2, input logic inject);
        got = '1;
        repeat (bc / 2 - 1) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            got[i] = tx_line;
            if (inject && i == 3) begin
                tx_data = d2; tx_load = 1'b1;
                @(negedge clk);
                tx_load = 1'b0;
                repeat (bc - 1) @(negedge clk);
            end else if (i < nb - 1) begin
                repeat (bc) @(negedge clk);
            end
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check(tx_line === 1'b1, "R1", "tx line high in reset", tx_line, 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(tx_line === 1'b1 && tx_done === 1'b0, "R1", "tx idle after reset",
              {tx_line, tx_done}, 2'b10);
        check(rx_done === 1'b0 && frame_err === 1'b0, "R1", "rx flags after reset",
              {rx_done, frame_err}, 0);
    endtask

    task automatic t_tx(input logic [1:0] m, input logic dbl, input int tp,
                        input logic [7:0] d, input logic b9, input string req);
        int nb, bc;
        logic [10:0] got, exp;
        mode = m; rate_double = dbl; tick_period = tp;
        nb = m[1] ? 11 : 10;
        bc = bit_clocks(m, dbl, tp);
        exp = frame_bits(d, b9, nb);
        repeat (4) @(negedge clk);
        pulse_load(d, b9);
        check(tx_done === 1'b0, "R9", "done cleared by load", tx_done, 0);
        collect_tx(nb, bc, got, 8'h00, 1'b0);
        check(got === exp, req, "tx frame bits", got, exp);
        check(tx_done === 1'b0, "R9", "done low during stop bit", tx_done, 0);
        repeat (bc / 2 + bc / 8) @(negedge clk);
        check(tx_done === 1'b1 && tx_line === 1'b1, "R9", "done after stop",
              {tx_done, tx_line}, 2'b11);
    endtask

    // A second load in mid-frame must not change the line.
    task automatic t_tx_busy_load();
        logic [10:0] got, exp;
        logic stayed;
        mode = 2'b01; rate_double = 1'b0; tick_period = 3;
        exp = frame_bits(8'hE1, 1'b0, 10);
        repeat (4) @(negedge clk);
        pulse_load(8'hE1, 1'b0);
        collect_tx(10, 48, got, 8'h1E, 1'b1);
        check(got === exp, "R9", "load while busy ignored", got, exp);
        stayed = 1'b1;
        for (int k = 0; k < 48 * 3; k++) begin
            @(negedge clk);
            if (tx_line !== 1'b1) stayed = 1'b0;
        end
        check(stayed === 1'b1 && tx_done === 1'b1, "R9", "no second frame",
              {stayed, tx_done}, 2'b11);
    endtask

    task automatic drive_rx(input logic [7:0] d, input logic b9, input int nb,
                            input int bc, input logic stop_v);
        logic [10:0] f;
        f = frame_bits(d, b9, nb);
        f[nb - 1] = stop_v;
        for (int i = 0; i < nb; i++) begin
            @(negedge clk);
            rx_line = f[i];
            repeat (bc - 1) @(negedge clk);
        end
        @(negedge clk);
        rx_line = 1'b1;
        repeat (bc / 2) @(negedge clk);
    endtask

    task automatic rx_flags_clear();
        @(negedge clk); rx_clear = 1'b1;
        @(negedge clk); rx_clear = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_rx(input logic [1:0] m, input logic dbl, input int tp,
                        input logic [7:0] d, input logic b9, input string req);
        int nb, bc;
        logic eb9;
        mode = m; rate_double = dbl; tick_period = tp;
        nb = m[1] ? 11 : 10;
        bc = bit_clocks(m, dbl, tp);
        eb9 = m[1] ? b9 : 1'b0;
        repeat (4) @(negedge clk);
        drive_rx(d, b9, nb, bc, 1'b1);
        check(rx_done === 1'b1 && frame_err === 1'b0, "R7", "done on good frame",
              {rx_done, frame_err}, 2'b10);
        check(rx_data === d, req, "rx byte", rx_data, d);
        check(rx_bit9 === eb9, "R7", "rx ninth bit", rx_bit9, eb9);
        rx_flags_clear();
        check(rx_done === 1'b0, "R10", "clear drops done", rx_done, 0);
    endtask

    // A low pulse shorter than half a bit is not a start bit.
    task automatic t_glitch();
        mode = 2'b01; tick_period = 3;
        repeat (4) @(negedge clk);
        rx_line = 1'b0;
        repeat (9) @(negedge clk);
        rx_line = 1'b1;
        repeat (48 * 12) @(negedge clk);
        check(rx_done === 1'b0 && frame_err === 1'b0, "R6", "glitch rejected",
              {rx_done, frame_err}, 0);
        drive_rx(8'h4B, 1'b0, 10, 48, 1'b1);
        check(rx_done === 1'b1 && rx_data === 8'h4B, "R6", "frame after glitch",
              {rx_done, rx_data}, {1'b1, 8'h4B});
        rx_flags_clear();
    endtask

    task automatic t_frame_err();
        mode = 2'b11; tick_period = 5;
        repeat (4) @(negedge clk);
        drive_rx(8'hD2, 1'b1, 11, 80, 1'b0);
        check(frame_err === 1'b1 && rx_done === 1'b0, "R8", "low stop flags error",
              {frame_err, rx_done}, 2'b10);
        check(rx_data === 8'h4B && rx_bit9 === 1'b0, "R8", "held data kept",
              {rx_bit9, rx_data}, {1'b0, 8'h4B});
        drive_rx(8'h2D, 1'b0, 11, 80, 1'b1);
        check(frame_err === 1'b0 && rx_done === 1'b1 && rx_data === 8'h2D, "R7",
              "good frame clears error", {frame_err, rx_done, rx_data}, {2'b01, 8'h2D});
        drive_rx(8'h77, 1'b1, 11, 80, 1'b0);
        rx_flags_clear();
        check(frame_err === 1'b0 && rx_done === 1'b0, "R10", "clear drops error",
              {frame_err, rx_done}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog run did not finish actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_tx(2'b01, 1'b0, 3, 8'hA5, 1'b0, "R2");
        t_tx(2'b00, 1'b0, 3, 8'h3C, 1'b1, "R2");
        t_tx(2'b11, 1'b0, 5, 8'h5A, 1'b1, "R4");
        t_tx(2'b11, 1'b0, 5, 8'hC3, 1'b0, "R5");
        t_tx(2'b10, 1'b0, 2, 8'h81, 1'b1, "R3");
        t_tx(2'b10, 1'b1, 2, 8'h36, 1'b0, "R3");
        t_tx_busy_load();
        t_rx(2'b01, 1'b0, 3, 8'h96, 1'b1, "R1");
        t_rx(2'b11, 1'b0, 5, 8'h69, 1'b1, "R4");
        t_rx(2'b10, 1'b0, 2, 8'h0F, 1'b0, "R3");
        t_rx(2'b10, 1'b1, 2, 8'hB4, 1'b1, "R3");
        t_glitch();
        t_frame_err();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule